// File: doc/BRIEF.md
# Descriptor Chain Walker

This block follows a chain of control blocks held in memory. A start strobe gives the address of the first block. The walker then fetches words one at a time over a word-read port. It reads the link to the following block and the block's info word, and then, for each data buffer that belongs to the block, a status word and a buffer address. Each buffer it accepts is offered to a consumer on a valid/ready handshake, together with its status word and the info word of its block. When the buffers of a block are used up, the walker follows the link. A zero link ends the chain.

Two modes share the same block layout: injection and extraction. In extraction mode each buffer address must be 64-bit aligned and each buffer length a multiple of 128 bytes. Descriptor addresses must be 64-bit aligned in both modes. A rule violation stops the walk and raises an error flag. The number of buffers per block comes from the channel configuration and is captured when the walk starts.

Top module: `dcb_chain_walker`

## Requirements
- R1: An accepted start makes the walker read from the start address. For a block at byte address B it reads the link at B, the info word at B+4, then the status word at B+8+8*i and the buffer address at B+12+8*i, for i = 0 up to the count minus 1, in that order.
- R2: Only one read is outstanding at a time. rd_req is high for exactly one cycle per read, and no further read is issued until rd_rsp_valid returns. A response with no read pending is ignored.
- R3: blk_count and extract are captured when a start is accepted. Each block yields exactly blk_count offers, and a count of 0 gives no offers while the chain is still followed.
- R4: While blk_valid is high and blk_ready is low, blk_valid, blk_addr, blk_status and blk_info hold their values.
- R5: A link word of zero ends the walk. list_done rises, busy falls, and no further read is issued.
- R6: A start address or non-zero link with any of bits [2:0] set raises err and ends the walk. No read is issued at that address.
- R7: In extraction mode, a buffer address with any of bits [2:0] set, or a status word with any of bits [6:0] set, raises err and ends the walk. That buffer is not offered. Bits [15:0] of the status word hold the buffer length in bytes.
- R8: In injection mode, buffer addresses and status words are offered unchecked, whatever their alignment or length.
- R9: A start strobe while busy is high is ignored, together with any change of start_addr, blk_count or extract.
- R10: list_done and err are levels that hold until the next accepted start clears them. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| start_addr | input | ADDR_W | Byte address of the first block |
| extract | input | 1 | 1 = extraction rules, 0 = injection |
| blk_count | input | CNT_W | Buffers per block |
| busy | output | 1 | Walk in progress |
| list_done | output | 1 | Chain ended on a zero link |
| err | output | 1 | Walk stopped on a rule violation |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Byte address of the read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DATA_W | Read data |
| blk_valid | output | 1 | Buffer offer valid |
| blk_ready | input | 1 | Consumer accepts the offer |
| blk_addr | output | ADDR_W | Buffer address |
| blk_status | output | DATA_W | Buffer status word |
| blk_info | output | DATA_W | Info word of the current block |

## Verification
A start strobe can arrive in the same cycle that the walker is fetching or offering. In that cycle, the new strobe competes with the walk already in progress. The bench pulses start a few cycles into a walk, with a different address, a different count and the opposite mode. It then checks that the full read-address sequence and the list of offers still match what the first start's settings predict. The bench also varies the read latency and stalls the consumer, so that responses and ready changes fall on different cycles relative to each other.

// File: rtl/dcbw_pkg.sv
package dcbw_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_NEXT,
      S_INFO,
      S_STAT,
      S_PTR,
      S_CHK,
      S_OFFER,
      S_LINK
   } walk_state_e;

   typedef enum logic [1:0] {
      SLOT_NEXT,
      SLOT_INFO,
      SLOT_STAT,
      SLOT_PTR
   } slot_e;

endpackage

// File: rtl/dcbw_rd_port.sv
module dcbw_rd_port #(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter bit RSP_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          want,
   input  logic [AW-1:0] want_addr,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_rsp_valid,
   input  logic [DW-1:0] rd_rsp_data,
   output logic          got,
   output logic [DW-1:0] got_data
);

   logic pend;

   assign rd_req  = want & ~pend;
   assign rd_addr = want_addr;

   generate
      if (RSP_REG == 1'b0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pend <= 1'b0;
            else if (rd_req)       pend <= 1'b1;
            else if (rd_rsp_valid) pend <= 1'b0;
         end
         assign got      = pend & rd_rsp_valid;
         assign got_data = rd_rsp_data;
      end else begin : g_reg
         logic          hit_q;
         logic [DW-1:0] dat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend  <= 1'b0;
               hit_q <= 1'b0;
               dat_q <= '0;
            end else begin
               hit_q <= pend & rd_rsp_valid & ~hit_q;
               if (pend & rd_rsp_valid & ~hit_q) dat_q <= rd_rsp_data;
               if (rd_req)     pend <= 1'b1;
               else if (hit_q) pend <= 1'b0;
            end
         end
         assign got      = hit_q;
         assign got_data = dat_q;
      end
   endgenerate

   // R2: a request is never followed directly by another
   assert_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req)
      else $error("second read issued while one is pending");

endmodule

// File: rtl/dcbw_slot_addr.sv
module dcbw_slot_addr
   import dcbw_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 4,
   parameter int WB = 4
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] idx,
   input  slot_e         sel,
   output logic [AW-1:0] addr
);

   localparam int PAIR_SH = $clog2(2 * WB);

   logic [AW-1:0] pair_off;
   logic [AW-1:0] off;

   assign pair_off = AW'(idx) << PAIR_SH;

   always_comb begin
      case (sel)
         SLOT_NEXT: off = '0;
         SLOT_INFO: off = AW'(WB);
         SLOT_STAT: off = AW'(2 * WB) + pair_off;
         default:   off = AW'(3 * WB) + pair_off;
      endcase
   end

   assign addr = base + off;

endmodule

// File: rtl/dcbw_rules.sv
module dcbw_rules #(
   parameter int DAB        = 3,
   parameter int BAB        = 3,
   parameter int LGB        = 7,
   parameter bit CHECK_BOTH = 1'b0
) (
   input  logic [DAB-1:0] desc_low,
   input  logic [BAB-1:0] ptr_low,
   input  logic [LGB-1:0] len_low,
   input  logic           extract,
   output logic           desc_ok,
   output logic           blk_ok
);

   logic ptr_ok;
   logic len_ok;

   assign desc_ok = (desc_low == '0);
   assign ptr_ok  = (ptr_low == '0);
   assign len_ok  = (len_low == '0);

   generate
      if (CHECK_BOTH) begin : g_both
         assign blk_ok = ptr_ok & (len_ok | ~extract);
      end else begin : g_ext_only
         assign blk_ok = ~extract | (ptr_ok & len_ok);
      end
   endgenerate

endmodule

// File: rtl/dcb_chain_walker.sv
module dcb_chain_walker
   import dcbw_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 4,
   parameter int DESC_AL_BITS  = 3,
   parameter int BUF_AL_BITS   = 3,
   parameter int LEN_GRAN_BITS = 7,
   parameter bit RSP_REG       = 1'b0,
   parameter bit CHECK_BOTH    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              extract,
   input  logic [CNT_W-1:0]  blk_count,
   output logic              busy,
   output logic              list_done,
   output logic              err,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_rsp_valid,
   input  logic [DATA_W-1:0] rd_rsp_data,
   output logic              blk_valid,
   input  logic              blk_ready,
   output logic [ADDR_W-1:0] blk_addr,
   output logic [DATA_W-1:0] blk_status,
   output logic [DATA_W-1:0] blk_info
);

   localparam int WORD_BYTES = DATA_W / 8;

   generate
      if (ADDR_W != DATA_W) begin : g_bad_width
         $error("pointer width must equal word width");
      end
      if (DATA_W % 32 != 0) begin : g_bad_word
         $error("word width must be a multiple of 32");
      end
      if (DESC_AL_BITS < 1 || BUF_AL_BITS < 1 || LEN_GRAN_BITS < 1) begin : g_bad_rule
         $error("rule widths must be at least one bit");
      end
      if (LEN_GRAN_BITS > DATA_W) begin : g_bad_len
         $error("length granule exceeds status word");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("count width must be at least one bit");
      end
   endgenerate

   walk_state_e       st;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] next_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [DATA_W-1:0] info_q;
   logic [DATA_W-1:0] stat_q;
   logic [CNT_W-1:0]  idx_q;
   logic [CNT_W-1:0]  idx_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              ext_q;
   logic              done_q;
   logic              err_q;

   slot_e             sel;
   logic              want;
   logic [ADDR_W-1:0] want_addr;
   logic              got;
   logic [DATA_W-1:0] got_data;
   logic [DESC_AL_BITS-1:0] desc_low;
   logic              desc_ok;
   logic              blk_ok;

   assign idx_nxt = idx_q + 1'b1;

   always_comb begin
      case (st)
         S_NEXT:  sel = SLOT_NEXT;
         S_INFO:  sel = SLOT_INFO;
         S_STAT:  sel = SLOT_STAT;
         default: sel = SLOT_PTR;
      endcase
   end

   assign want = (st == S_NEXT) || (st == S_INFO) || (st == S_STAT) || (st == S_PTR);
   assign desc_low = (st == S_IDLE) ? start_addr[DESC_AL_BITS-1:0]
                                    : next_q[DESC_AL_BITS-1:0];

   dcbw_slot_addr #(
      .AW (ADDR_W),
      .CW (CNT_W),
      .WB (WORD_BYTES)
   ) u_slot (
      .base (base_q),
      .idx  (idx_q),
      .sel  (sel),
      .addr (want_addr)
   );

   dcbw_rd_port #(
      .AW      (ADDR_W),
      .DW      (DATA_W),
      .RSP_REG (RSP_REG)
   ) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .want         (want),
      .want_addr    (want_addr),
      .rd_req       (rd_req),
      .rd_addr      (rd_addr),
      .rd_rsp_valid (rd_rsp_valid),
      .rd_rsp_data  (rd_rsp_data),
      .got          (got),
      .got_data     (got_data)
   );

   dcbw_rules #(
      .DAB        (DESC_AL_BITS),
      .BAB        (BUF_AL_BITS),
      .LGB        (LEN_GRAN_BITS),
      .CHECK_BOTH (CHECK_BOTH)
   ) u_rules (
      .desc_low (desc_low),
      .ptr_low  (ptr_q[BUF_AL_BITS-1:0]),
      .len_low  (stat_q[LEN_GRAN_BITS-1:0]),
      .extract  (ext_q),
      .desc_ok  (desc_ok),
      .blk_ok   (blk_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         base_q <= '0;
         next_q <= '0;
         ptr_q  <= '0;
         info_q <= '0;
         stat_q <= '0;
         idx_q  <= '0;
         cnt_q  <= '0;
         ext_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         case (st)
            S_IDLE: begin
               if (start) begin
                  done_q <= 1'b0;
                  if (desc_ok) begin
                     err_q  <= 1'b0;
                     base_q <= start_addr;
                     cnt_q  <= blk_count;
                     ext_q  <= extract;
                     st     <= S_NEXT;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            S_NEXT: begin
               if (got) begin
                  next_q <= got_data;
                  st     <= S_INFO;
               end
            end
            S_INFO: begin
               if (got) begin
                  info_q <= got_data;
                  idx_q  <= '0;
                  st     <= (cnt_q == '0) ? S_LINK : S_STAT;
               end
            end
            S_STAT: begin
               if (got) begin
                  stat_q <= got_data;
                  st     <= S_PTR;
               end
            end
            S_PTR: begin
               if (got) begin
                  ptr_q <= got_data;
                  st    <= S_CHK;
               end
            end
            S_CHK: begin
               if (blk_ok) begin
                  st <= S_OFFER;
               end else begin
                  err_q <= 1'b1;
                  st    <= S_IDLE;
               end
            end
            S_OFFER: begin
               if (blk_ready) begin
                  if (idx_nxt == cnt_q) begin
                     st <= S_LINK;
                  end else begin
                     idx_q <= idx_nxt;
                     st    <= S_STAT;
                  end
               end
            end
            S_LINK: begin
               if (next_q == '0) begin
                  done_q <= 1'b1;
                  st     <= S_IDLE;
               end else if (!desc_ok) begin
                  err_q <= 1'b1;
                  st    <= S_IDLE;
               end else begin
                  base_q <= next_q;
                  st     <= S_NEXT;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy       = (st != S_IDLE);
   assign list_done  = done_q;
   assign err        = err_q;
   assign blk_valid  = (st == S_OFFER);
   assign blk_addr   = ptr_q;
   assign blk_status = stat_q;
   assign blk_info   = info_q;

   // R4: a stalled offer keeps all of its fields
   assert_offer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid && !blk_ready |=> blk_valid && $stable(blk_addr)
                                  && $stable(blk_status) && $stable(blk_info))
      else $error("offer changed while stalled");

   // R10: the two end flags exclude each other
   assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(list_done && err))
      else $error("done and error both set");

   // R5: a finished chain leaves the walker idle and silent
   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      list_done |-> !busy && !rd_req)
      else $error("activity after chain end");

   // R6, R7: an error halts all reads and offers
   assert_err_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy && !rd_req && !blk_valid)
      else $error("activity after error");

   // R1: every fetch lands on a word boundary
   assert_rd_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> rd_addr[1:0] == 2'b00)
      else $error("unaligned read address");

endmodule

// File: tb/dcb_chain_walker_tb_top.sv
`timescale 1ns/1ps
module dcb_chain_walker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_addr = '0;
   logic        extract = 1'b0;
   logic [3:0]  blk_count = '0;
   logic        busy, list_done, err, rd_req, blk_valid;
   logic [31:0] rd_addr, blk_addr, blk_status, blk_info;
   logic        rd_rsp_valid = 1'b0;
   logic [31:0] rd_rsp_data = '0;
   logic        blk_ready = 1'b0;

   always #2 clk = ~clk;

   dcb_chain_walker dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_addr   (start_addr),
      .extract      (extract),
      .blk_count    (blk_count),
      .busy         (busy),
      .list_done    (list_done),
      .err          (err),
      .rd_req       (rd_req),
      .rd_addr      (rd_addr),
      .rd_rsp_valid (rd_rsp_valid),
      .rd_rsp_data  (rd_rsp_data),
      .blk_valid    (blk_valid),
      .blk_ready    (blk_ready),
      .blk_addr     (blk_addr),
      .blk_status   (blk_status),
      .blk_info     (blk_info)
   );

   logic [31:0] mem [0:255];
   int n_chk = 0;
   int n_fail = 0;
   int g_lat = 1;
   int g_stall = 0;

   logic [31:0] act_rd[$], act_oa[$], act_os[$], act_oi[$];
   logic [31:0] exp_rd[$], exp_oa[$], exp_os[$], exp_oi[$];
   logic        exp_done, exp_err;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory responder: one response, g_lat cycles after each request
   initial begin
      forever begin
         logic [31:0] a;
         @(negedge clk);
         rd_rsp_valid = 1'b0;
         if (rd_req) begin
            a = rd_addr;
            act_rd.push_back(a);
            repeat (g_lat) @(negedge clk);
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem[a[9:2]];
         end
      end
   end

   // consumer: stalls g_stall cycles per offer
   initial begin
      int sc;
      sc = 0;
      forever begin
         @(negedge clk);
         if (blk_valid) begin
            if (sc < g_stall) begin
               blk_ready = 1'b0;
               sc++;
            end else begin
               blk_ready = 1'b1;
               act_oa.push_back(blk_addr);
               act_os.push_back(blk_status);
               act_oi.push_back(blk_info);
               sc = 0;
            end
         end else begin
            blk_ready = 1'b0;
            sc = 0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   task automatic put_desc(input logic [31:0] d, input logic [31:0] nx, input logic [31:0] inf);
      mem[d[9:2]]       = nx;
      mem[d[9:2] + 8'd1] = inf;
   endtask

   task automatic put_blk(input logic [31:0] d, input int i,
                          input logic [31:0] stw, input logic [31:0] p);
      logic [31:0] sa;
      sa = d + 32'd8 + 32'(8 * i);
      mem[sa[9:2]]        = stw;
      mem[sa[9:2] + 8'd1] = p;
   endtask

   // expected walk derived from the requirements
   task automatic model(input logic [31:0] sa, input int cnt, input bit ext);
      logic [31:0] d, nx, inf, stw, p, a1, a2;
      exp_rd.delete(); exp_oa.delete(); exp_os.delete(); exp_oi.delete();
      exp_done = 1'b0;
      exp_err  = 1'b0;
      d = sa;
      if (d[2:0] != 3'b000) begin
         exp_err = 1'b1;
         return;
      end
      for (int g = 0; g < 16; g++) begin
         exp_rd.push_back(d);
         exp_rd.push_back(d + 32'd4);
         nx  = mem[d[9:2]];
         a1  = d + 32'd4;
         inf = mem[a1[9:2]];
         for (int i = 0; i < cnt; i++) begin
            a1 = d + 32'd8 + 32'(8 * i);
            a2 = a1 + 32'd4;
            exp_rd.push_back(a1);
            exp_rd.push_back(a2);
            stw = mem[a1[9:2]];
            p   = mem[a2[9:2]];
            if (ext && (p[2:0] != 3'b000 || stw[6:0] != 7'd0)) begin
               exp_err = 1'b1;
               return;
            end
            exp_oa.push_back(p);
            exp_os.push_back(stw);
            exp_oi.push_back(inf);
         end
         if (nx == 32'd0) begin
            exp_done = 1'b1;
            return;
         end
         if (nx[2:0] != 3'b000) begin
            exp_err = 1'b1;
            return;
         end
         d = nx;
      end
   endtask

   task automatic run_case(input string req, input logic [31:0] sa, input int cnt,
                           input bit ext, input int lat, input int stall,
                           input bit ghost, input logic [31:0] ghost_addr);
      int mism;
      model(sa, cnt, ext);
      g_lat   = lat;
      g_stall = stall;
      act_rd.delete(); act_oa.delete(); act_os.delete(); act_oi.delete();
      @(negedge clk);
      start      = 1'b1;
      start_addr = sa;
      blk_count  = 4'(cnt);
      extract    = ext;
      @(negedge clk);
      start = 1'b0;
      if (ghost) begin
         repeat (3) @(negedge clk);
         start      = 1'b1;
         start_addr = ghost_addr;
         blk_count  = 4'(cnt + 1);
         extract    = ~ext;
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(act_rd.size() == exp_rd.size(), req, "read count",
          32'(act_rd.size()), 32'(exp_rd.size()));
      mism = 0;
      for (int i = 0; i < act_rd.size() && i < exp_rd.size(); i++)
         if (act_rd[i] !== exp_rd[i]) mism++;
      chk(mism == 0, req, "read address mismatches", 32'(mism), 32'd0);
      chk(act_oa.size() == exp_oa.size(), req, "offer count",
          32'(act_oa.size()), 32'(exp_oa.size()));
      mism = 0;
      for (int i = 0; i < act_oa.size() && i < exp_oa.size(); i++)
         if (act_oa[i] !== exp_oa[i] || act_os[i] !== exp_os[i] || act_oi[i] !== exp_oi[i])
            mism++;
      chk(mism == 0, req, "offer field mismatches", 32'(mism), 32'd0);
      chk(list_done === exp_done, req, "list_done", 32'(list_done), 32'(exp_done));
      chk(err === exp_err, req, "err", 32'(err), 32'(exp_err));
      chk(busy === 1'b0, req, "busy after walk", 32'(busy), 32'd0);
   endtask

   task automatic t_reset;
      chk(busy === 1'b0 && rd_req === 1'b0 && blk_valid === 1'b0, "R5",
          "reset idle outputs", {29'd0, busy, rd_req, blk_valid}, 32'd0);
      chk(list_done === 1'b0 && err === 1'b0, "R10", "reset flags",
          {30'd0, list_done, err}, 32'd0);
   endtask

   // R1 R3 R5: two-block injection chain, fast memory, eager consumer
   task automatic t_inject_chain;
      run_case("R1_R3_R5 inject chain", 32'h040, 2, 1'b0, 1, 0, 1'b0, 32'h0);
   endtask

   // R4 R7: clean extraction chain, slow memory, stalling consumer
   task automatic t_extract_clean;
      run_case("R4_R7 extract clean", 32'h200, 3, 1'b1, 3, 2, 1'b0, 32'h0);
   endtask

   // R3: zero buffers per block still follows the chain
   task automatic t_zero_count;
      run_case("R3 zero count", 32'h040, 0, 1'b0, 2, 0, 1'b0, 32'h0);
   endtask

   // R7: bad extraction length on the second buffer
   task automatic t_bad_len;
      run_case("R7 bad length", 32'h300, 2, 1'b1, 1, 1, 1'b0, 32'h0);
   endtask

   // R7: misaligned extraction buffer
   task automatic t_bad_ptr;
      run_case("R7 bad pointer", 32'h340, 1, 1'b1, 2, 0, 1'b0, 32'h0);
   endtask

   // R8: same faulty buffers accepted in injection mode
   task automatic t_inject_unchecked;
      run_case("R8 inject unchecked", 32'h300, 2, 1'b0, 1, 0, 1'b0, 32'h0);
      run_case("R8 inject unchecked ptr", 32'h340, 1, 1'b0, 1, 0, 1'b0, 32'h0);
   endtask

   // R6: misaligned link after one block
   task automatic t_bad_link;
      run_case("R6 bad link", 32'h380, 1, 1'b0, 1, 0, 1'b0, 32'h0);
   endtask

   // R6 R10: misaligned start clears the previous done, sets err, no reads
   task automatic t_bad_start;
      run_case("R6_R10 bad start", 32'h044, 2, 1'b0, 1, 0, 1'b0, 32'h0);
   endtask

   // R9: start during a walk with different settings is ignored
   task automatic t_start_busy;
      run_case("R9 start while busy", 32'h040, 2, 1'b0, 2, 1, 1'b1, 32'h300);
      run_case("R9_R10 restart after error", 32'h200, 3, 1'b1, 1, 0, 1'b1, 32'h044);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      // injection chain 0x040 -> 0x100
      put_desc(32'h040, 32'h100, 32'h0000_00A1);
      put_blk(32'h040, 0, 32'h0000_0080, 32'h0000_2000);
      put_blk(32'h040, 1, 32'h0000_0100, 32'h0000_2100);
      put_desc(32'h100, 32'h000, 32'h0000_00A2);
      put_blk(32'h100, 0, 32'h0000_0044, 32'h0000_2200);
      put_blk(32'h100, 1, 32'h5500_0080, 32'h0000_2300);
      // extraction chain 0x200 -> 0x280
      put_desc(32'h200, 32'h280, 32'h0000_00B1);
      put_blk(32'h200, 0, 32'h0000_0080, 32'h0000_3000);
      put_blk(32'h200, 1, 32'h0000_0000, 32'h0000_3100);
      put_blk(32'h200, 2, 32'h0001_0100, 32'h0000_3208);
      put_desc(32'h280, 32'h000, 32'h0000_00B2);
      put_blk(32'h280, 0, 32'h0000_0180, 32'h0000_3400);
      put_blk(32'h280, 1, 32'h0000_0200, 32'h0000_3500);
      put_blk(32'h280, 2, 32'h0000_0080, 32'h0000_3600);
      // faulty length at 0x300
      put_desc(32'h300, 32'h000, 32'h0000_00C1);
      put_blk(32'h300, 0, 32'h0000_0080, 32'h0000_4000);
      put_blk(32'h300, 1, 32'h0000_0064, 32'h0000_4100);
      // faulty pointer at 0x340
      put_desc(32'h340, 32'h000, 32'h0000_00C2);
      put_blk(32'h340, 0, 32'h0000_0080, 32'h0000_4204);
      // misaligned link at 0x380
      put_desc(32'h380, 32'h3C4, 32'h0000_00C3);
      put_blk(32'h380, 0, 32'h0000_0080, 32'h0000_4300);

      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_inject_chain();
      t_extract_clean();
      t_zero_count();
      t_bad_len();
      t_bad_ptr();
      t_inject_unchecked();
      t_bad_link();
      t_inject_chain();
      t_bad_start();
      t_start_busy();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule